// File: doc/BRIEF.md
# Rounding Scale-Divide Unit for Histogram Equalization

This unit turns the per-frame count of one intensity bin into that bin's equalized output level. Each clock it takes a small count, the number of pixels in that beat that fall at or below the bin's level. When the frame ends it produces round((L-1)·S/n). Here S is the sum of the counts over the frame, L = 2^PIX_W is the number of levels and n is the fixed frame pixel count. The unit uses no multiplier and no divider. Multiplying by L-1 is done by concatenation and addition. Dividing by n is a running accumulator that subtracts n whenever the sum reaches it, and each such subtraction increments a quotient.

The accumulate loop is three registers deep: add, subtract, select. Three remainder lanes therefore circulate at the same time, and they share one quotient. One lane is seeded with n/2 at the start of a frame, which turns truncation into round-half-up. A single frame-sync pulse closes the frame. A shift register of delayed sync taps then performs the remaining steps in order:
- re-seed the lanes,
- capture the old lanes and the quotient,
- fold the three remainders by chained subtraction of n,
- load the output register.

Top module: `eqmap_scale_div`

## Requirements
- R1: While reset is asserted, level_o is 0. Reset also opens a frame, so the beats that follow reset are accumulated and rounded exactly like the beats of any later frame.
- R2: For a frame whose sum of count_i over the beats with frame_sync_i low is S, the result is min(L-1, floor(((L-1)·S + n/2)/n)), using integer n/2.
- R3: On a beat with frame_sync_i high, count_i is ignored and adds nothing to either the closing frame or the next frame.
- R4: level_o changes only on the 6th rising edge after the edge that samples frame_sync_i high. Between such updates it holds its value.
- R5: An exact half rounds up. For example, with n = 4096 and 8-bit levels, S = 2048 gives 128, while S = 2047 gives 127.
- R6: When (L-1)·S/n rounds above L-1, the result saturates at L-1.
- R7: Frame-sync pulses may arrive as often as every 6th beat, which leaves 5 data beats between them. Each frame's result is independent of the neighbouring frames; the quotient restarts at 0 for every frame.
- R8: Each remainder lane stays below n for every beat, including a frame in which every beat carries the maximum count.
- R9: A frame in which every count is 0 gives level 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync_i | input | 1 | High for one beat to close the current frame; count_i is ignored on that beat |
| count_i | input | CNT_W | Count increment for this beat |
| level_o | output | PIX_W | Registered equalized level of the last closed frame |

## Verification
Two functions overlap across a frame boundary and can act in the same cycle. The first is seeding the new frame's lanes and clearing the quotient. The second is capturing the closing frame's last remainders and its last quotient increment. The bench provokes the overlap by putting maximum counts on the beats right before and right after a sync, and by running frames at the minimum spacing of six beats. A result that lost the closing frame's last increment, or let the new frame leak in, would differ by at least one level from the exact integer model computed for each frame.

// File: rtl/eqsd_pkg.sv
package eqsd_pkg;
   // Tap k of the sync delay chain is high k+1 cycles after the sync beat.
   localparam int TAP_N        = 6;
   localparam int TAP_SEED_HI  = 1;   // seed the first lane of the new frame with n/2
   localparam int TAP_SEED_LO0 = 2;   // seed the second lane with zero, capture the quotient
   localparam int TAP_SEED_LO1 = 3;   // seed the third lane with zero
   localparam int TAP_FOLD     = 4;   // chained subtraction of the folded remainders
   localparam int TAP_OUT      = 5;   // output register enable

   function automatic int acc_bits(input int n);
      return $clog2(n) + 2;
   endfunction
endpackage

// File: rtl/eqsd_taps.sv
module eqsd_taps #(
   parameter int TAPS = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            sync_i,
   output logic [TAPS-1:1] taps_o
);
   logic [TAPS-1:0] chain_q;

   always_ff @(posedge clk) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[TAPS-2:0], sync_i};
   end

   assign taps_o = chain_q[TAPS-1:1];

   AST_SYNC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |-> (chain_q[TAPS-2:0] == '0)); // R7
endmodule

// File: rtl/eqsd_scale.sv
module eqsd_scale #(
   parameter int PIX_W       = 8,
   parameter int CNT_W       = 4,
   parameter int ACC_W       = 14,
   parameter bit CONCAT_FORM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [ACC_W-1:0] sc_o
);
   localparam int SC_W    = CNT_W + PIX_W;
   localparam int LVL_MAX = (1 << PIX_W) - 1;

   logic [SC_W-1:0] prod;

   generate
      if (CONCAT_FORM) begin : g_concat
         // v*2^w + 1 plus the full-width inverse of v equals v*(2^w - 1)
         assign prod = {cnt_i, {(PIX_W-1){1'b0}}, 1'b1} + {{PIX_W{1'b1}}, ~cnt_i};
      end else begin : g_shift_sub
         assign prod = {cnt_i, {PIX_W{1'b0}}} - SC_W'(cnt_i);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      sc_o <= '0;
      else if (sync_i) sc_o <= '0;
      else             sc_o <= ACC_W'(prod);
   end

   AST_SCALE_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_i |=> (sc_o == ACC_W'($past(cnt_i)) * ACC_W'(LVL_MAX))); // R2
   AST_SYNC_COUNT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      sync_i |=> (sc_o == '0)); // R3
endmodule

// File: rtl/eqsd_loop.sv
module eqsd_loop #(
   parameter int ACC_W = 14,
   parameter int N_PIX = 4096,
   parameter int Q_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ACC_W-1:0] sc_i,
   input  logic             seed_hi_i,
   input  logic             seed_lo_i,
   input  logic             qclr_i,
   output logic [ACC_W-1:0] rem_o,
   output logic [Q_W-1:0]   quot_o
);
   localparam logic [ACC_W-1:0] N_ACC = ACC_W'(N_PIX);
   localparam logic [ACC_W-1:0] HALF  = ACC_W'(N_PIX / 2);

   logic [ACC_W-1:0] base, sum_q, sum2_q, diff_q;
   logic             neg;

   // Lane value entering the adder: the circulating remainder or a frame seed.
   always_comb begin
      if (seed_hi_i)      base = HALF;
      else if (seed_lo_i) base = '0;
      else                base = rem_o;
   end

   assign neg = diff_q[ACC_W-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sum_q  <= '0;
         sum2_q <= '0;
         diff_q <= '1;          // negative: the first selects keep zero
         rem_o  <= HALF;        // reset opens a frame with the n/2 seed
         quot_o <= '0;
      end else begin
         sum_q  <= sc_i + base;              // stage 1: add
         sum2_q <= sum_q;                    // stage 2: subtract n
         diff_q <= sum_q - N_ACC;
         rem_o  <= neg ? sum2_q : diff_q;    // stage 3: select by sign
         if (qclr_i)                         quot_o <= '0;
         else if (!neg && (quot_o != '1))    quot_o <= quot_o + 1'b1;
      end
   end

   AST_REM_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
      rem_o < N_ACC); // R8
   AST_QUOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      qclr_i |=> (quot_o == '0)); // R7
   AST_HALF_SEED: assert property (@(posedge clk) disable iff (!rst_n)
      seed_hi_i |=> (sum_q >= HALF)); // R5
endmodule

// File: rtl/eqsd_integ.sv
module eqsd_integ #(
   parameter int ACC_W = 14,
   parameter int N_PIX = 4096,
   parameter int Q_W   = 10,
   parameter int PIX_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_first_i,
   input  logic             cap_more_i,
   input  logic             qcap_i,
   input  logic             fold_i,
   input  logic             out_en_i,
   input  logic [ACC_W-1:0] rem_i,
   input  logic [Q_W-1:0]   quot_i,
   output logic [PIX_W-1:0] level_o
);
   localparam int E_W = ACC_W + 2;
   localparam logic [E_W-1:0]   N_E     = E_W'(N_PIX);
   localparam logic [Q_W:0]     LVL_MAX = (Q_W+1)'((1 << PIX_W) - 1);
   localparam logic [ACC_W:0]   CS_MAX  = (ACC_W+1)'(3 * N_PIX);

   logic [ACC_W:0]   csum_q;
   logic [Q_W-1:0]   qcap_q;
   logic [E_W-1:0]   d1, d2, d3;
   logic [2:0]       ge_q;
   logic [Q_W:0]     total;

   // Chain of three subtractions of n from the folded remainder sum.
   assign d1 = {1'b0, csum_q} - N_E;
   assign d2 = d1 - N_E;
   assign d3 = d2 - N_E;

   assign total = (Q_W+1)'(qcap_q) + (Q_W+1)'(ge_q[0])
                + (Q_W+1)'(ge_q[1]) + (Q_W+1)'(ge_q[2]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         csum_q  <= '0;
         qcap_q  <= '0;
         ge_q    <= '0;
         level_o <= '0;
      end else begin
         if (cap_first_i)     csum_q <= (ACC_W+1)'(rem_i);
         else if (cap_more_i) csum_q <= csum_q + (ACC_W+1)'(rem_i);
         if (qcap_i)          qcap_q <= quot_i;
         if (fold_i)          ge_q   <= {~d3[E_W-1], ~d2[E_W-1], ~d1[E_W-1]};
         if (out_en_i)        level_o <= (total > LVL_MAX) ? LVL_MAX[PIX_W-1:0]
                                                          : total[PIX_W-1:0];
      end
   end

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en_i |=> $stable(level_o)); // R4
   AST_FOLD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      csum_q < CS_MAX); // R8
   AST_ONE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({cap_first_i, cap_more_i})); // R7
endmodule

// File: rtl/eqmap_scale_div.sv
module eqmap_scale_div #(
   parameter int PIX_W       = 8,
   parameter int CNT_W       = 4,
   parameter int N_PIX       = 4096,
   parameter bit CONCAT_FORM = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_sync_i,
   input  logic [CNT_W-1:0] count_i,
   output logic [PIX_W-1:0] level_o
);
   import eqsd_pkg::*;

   localparam int ACC_W = acc_bits(N_PIX);
   localparam int Q_W   = PIX_W + 2;

   // One conditional subtraction per beat needs the scaled count below n.
   generate
      if (((1 << CNT_W) - 1) * ((1 << PIX_W) - 1) >= N_PIX) begin : g_bad_n
         $error("N_PIX must exceed the largest scaled count");
      end
      if (PIX_W < 2) begin : g_bad_pix
         $error("PIX_W must be at least 2");
      end
      if (N_PIX < 2) begin : g_bad_min
         $error("N_PIX must be at least 2");
      end
   endgenerate

   logic [TAP_N-1:1] taps;
   logic [ACC_W-1:0] sc, rem;
   logic [Q_W-1:0]   quot;

   eqsd_taps #(.TAPS(TAP_N)) u_taps (
      .clk(clk), .rst_n(rst_n), .sync_i(frame_sync_i), .taps_o(taps));

   eqsd_scale #(.PIX_W(PIX_W), .CNT_W(CNT_W), .ACC_W(ACC_W), .CONCAT_FORM(CONCAT_FORM))
   u_scale (
      .clk(clk), .rst_n(rst_n), .sync_i(frame_sync_i), .cnt_i(count_i), .sc_o(sc));

   eqsd_loop #(.ACC_W(ACC_W), .N_PIX(N_PIX), .Q_W(Q_W)) u_loop (
      .clk(clk), .rst_n(rst_n), .sc_i(sc),
      .seed_hi_i(taps[TAP_SEED_HI]),
      .seed_lo_i(taps[TAP_SEED_LO0] | taps[TAP_SEED_LO1]),
      .qclr_i(taps[TAP_SEED_LO0]),
      .rem_o(rem), .quot_o(quot));

   eqsd_integ #(.ACC_W(ACC_W), .N_PIX(N_PIX), .Q_W(Q_W), .PIX_W(PIX_W)) u_integ (
      .clk(clk), .rst_n(rst_n),
      .cap_first_i(taps[TAP_SEED_HI]),
      .cap_more_i(taps[TAP_SEED_LO0] | taps[TAP_SEED_LO1]),
      .qcap_i(taps[TAP_SEED_LO0]),
      .fold_i(taps[TAP_FOLD]),
      .out_en_i(taps[TAP_OUT]),
      .rem_i(rem), .quot_i(quot), .level_o(level_o));
endmodule

// File: tb/eqmap_scale_div_bench.sv
`timescale 1ns/1ps
module eqmap_scale_div_bench;
   localparam int PIX_W   = 8;
   localparam int CNT_W   = 4;
   localparam int N_PIX   = 4096;
   localparam int LVL_MAX = (1 << PIX_W) - 1;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic             clk = 1'b0;
   logic             rst_n;
   logic             frame_sync_i;
   logic [CNT_W-1:0] count_i;
   logic [PIX_W-1:0] level_o;

   eqmap_scale_div #(.PIX_W(PIX_W), .CNT_W(CNT_W), .N_PIX(N_PIX)) u_eqmap_scale_div (
      .clk(clk), .rst_n(rst_n), .frame_sync_i(frame_sync_i),
      .count_i(count_i), .level_o(level_o));

   always #2 clk = ~clk;

   int          checks = 0;
   int          failures = 0;
   bit          done = 1'b0;
   int unsigned run_sum = 0;
   int unsigned sync_exp = 0;
   string       sync_tag = "";
   int unsigned last_exp = 0;
   bit          sh_v [8];
   int unsigned sh_e [8];
   string       sh_t [8];

   function automatic int unsigned model(input int unsigned s);
      int unsigned v;
      v = (LVL_MAX * s + N_PIX / 2) / N_PIX;
      return (v > LVL_MAX) ? LVL_MAX : v;
   endfunction

   task automatic chk(input int unsigned act, input int unsigned exp, input string tag,
                      input string what);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   // Expected results travel with the sync beat that closes their frame.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < 8; k++) sh_v[k] = 1'b0;
      end else begin
         for (int k = 7; k > 0; k--) begin
            sh_v[k] = sh_v[k-1]; sh_e[k] = sh_e[k-1]; sh_t[k] = sh_t[k-1];
         end
         sh_v[0] = frame_sync_i; sh_e[0] = sync_exp; sh_t[0] = sync_tag;
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         if (sh_v[5]) chk(level_o, last_exp, "R4", "hold before update");
         if (sh_v[6]) begin
            chk(level_o, sh_e[6], sh_t[6], "frame result");
            last_exp = sh_e[6];
         end
      end
   end

   task automatic beat(input int unsigned c);
      @(negedge clk);
      frame_sync_i = 1'b0;
      count_i      = CNT_W'(c);
      run_sum     += c;
   endtask

   task automatic close(input string tag, input int unsigned junk);
      @(negedge clk);
      sync_exp     = model(run_sum);
      sync_tag     = tag;
      frame_sync_i = 1'b1;
      count_i      = CNT_W'(junk);
      run_sum      = 0;
   endtask

   task automatic fill(input int unsigned total, input string tag);
      int unsigned left;
      left = total;
      while (left > 0) begin
         beat((left > CNT_MAX) ? CNT_MAX : left);
         left -= (left > CNT_MAX) ? CNT_MAX : left;
      end
      close(tag, CNT_MAX);
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; frame_sync_i = 1'b0; count_i = '0;
      repeat (4) @(negedge clk);
      chk(level_o, 0, "R1", "level during reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk(level_o, 0, "R1", "level after reset");

      fill(1000, "R1");                 // first frame seeded by reset: 62
      repeat (20) beat(0);
      close("R9", CNT_MAX);             // all-zero frame: 0
      fill(2048, "R5");                 // exact half: 128
      fill(2047, "R5");                 // just below: 127
      fill(4095, "R8");                 // max counts on every beat: 255
      fill(4096, "R6");                 // full frame: 255
      fill(5000, "R6");                 // over range: saturates at 255
      repeat (10) beat(10);
      close("R3", CNT_MAX);             // junk count on sync beat ignored: 6

      // Minimum spacing with max counts around each boundary.
      repeat (4) begin
         repeat (5) beat(CNT_MAX);
         close("R7", CNT_MAX);
      end
      repeat (3) begin
         repeat (5) beat($urandom % (CNT_MAX + 1));
         close("R7", $urandom % (CNT_MAX + 1));
      end

      // Constrained random frames of mixed lengths.
      for (int f = 0; f < 30; f++) begin
         int unsigned len;
         len = (($urandom % 4) == 0) ? 5 : 6 + ($urandom % 200);
         for (int b = 0; b < int'(len); b++) beat($urandom % (CNT_MAX + 1));
         close("R2", $urandom % (CNT_MAX + 1));
      end

      repeat (12) beat(0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule